// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This unit multiplies two N-bit integers over N+1 clock cycles. It uses a single N+1-bit adder/subtractor and one 2N-bit product register. The register is split into a high half and a low half. The low half starts out holding the multiplier, so no separate multiplier register is needed. On every step the unit looks at the lowest bit of the low half. If that bit is 1, it adds the multiplicand into the high half. In the same cycle it shifts the whole register right by one bit. A mode input chooses unsigned or two's-complement operation.

In signed mode, both the multiplicand and the high half are sign-extended to N+1 bits before the add. If the multiplier is negative, the final step subtracts the multiplicand instead of adding it.

A controller steps through three named states:
- `S_IDLE` waits for `start`.
- `S_STEP` performs one iteration per cycle under an iteration counter.
- `S_FINISH` raises `done` for one cycle.

The transitions are:
- *launch*: `S_IDLE`→`S_STEP` on `start`.
- *iterate*: `S_STEP`→`S_STEP` while steps remain.
- *complete*: `S_STEP`→`S_FINISH` after the N-th step.
- *retire*: `S_FINISH`→`S_IDLE`, unconditionally.

Top module: `shiftmul_top`

## Requirements
- R1: After reset, `busy`, `done`, `prod_hi` and `prod_lo` are all zero.
- R2: When `start` is high in idle, the operands and mode are captured and `busy` is high in the following cycle.
- R3: `done` is high in the cycle after the N-th rising edge that follows the edge accepting `start`, and `busy` falls together with `done`.
- R4: With `mode_signed`=0, {`prod_hi`,`prod_lo`} equals the unsigned product of `mcand` and `mplier`, including a carry out of the high half.
- R5: With `mode_signed`=1, {`prod_hi`,`prod_lo`} equals the two's-complement product for every sign combination, including a negative multiplier, which is handled by the final subtract.
- R6: Extreme operands give exact results: all-ones times all-ones unsigned, and most-negative times most-negative or times most-positive signed.
- R7: A `start` pulse while `busy` is ignored: neither the result nor the completion time of the running operation changes.
- R8: After `done`, the product outputs stay constant until the next accepted `start`, whatever the operand and mode inputs do.
- R9: `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| mode_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier |
| busy | output | 1 | Operation in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | N | Upper half of the product |
| prod_lo | output | N | Lower half of the product |

## Verification
The hardest path to reach is the final-step subtract. It fires only when signed mode is selected and the multiplier's top bit is set. It also interacts with sign-extended shifts on every earlier step. The stimulus table therefore mixes each sign pairing with most-negative and most-positive operands. A second 4-bit instance replays small known products.

The carry out of the high half in unsigned mode needs large operands, so all-ones operands are applied. Rejection of `start` mid-operation is exercised by pulsing `start` with different operands part way through a run. The run's result and its timing are then checked against the first request.

// File: rtl/shiftmul_pkg.sv
package shiftmul_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STEP   = 2'd1,
        S_FINISH = 2'd2
    } mul_state_e;
endpackage

// File: rtl/shiftmul_ctrl.sv
module shiftmul_ctrl
    import shiftmul_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last_step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N - 1);

    mul_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, iterate, complete, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_STEP;
            S_STEP:   if (cnt_q == LAST_IDX) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        step      = 1'b0;
        last_step = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:   load = start;
            S_STEP: begin
                step      = 1'b1;
                busy      = 1'b1;
                last_step = (cnt_q == LAST_IDX);
            end
            S_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP) |-> (cnt_q < CNT_W'(N))); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && start && !last_step) |=> (state_q == S_STEP && cnt_q == $past(cnt_q) + 1'b1)); // R7
    AST_FINISH_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |=> (state_q == S_IDLE)); // R9
endmodule

// File: rtl/shiftmul_addsub.sv
module shiftmul_addsub #(
    parameter int N = 32
) (
    input  logic [N:0] acc_ext,
    input  logic [N:0] md_ext,
    input  logic       en_add,
    input  logic       negate,
    output logic [N:0] sum
);
    logic [N:0] operand;

    always_comb begin
        operand = md_ext ^ {(N + 1){negate}};
        if (en_add) sum = acc_ext + operand + {{N{1'b0}}, negate};
        else        sum = acc_ext;
    end
endmodule

// File: rtl/shiftmul_datapath.sv
module shiftmul_datapath #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         last_step,
    input  logic         busy,
    input  logic         mode_signed,
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic [N-1:0] hi,
    output logic [N-1:0] lo
);
    logic [N-1:0] hi_q, lo_q, md_q;
    logic         sgn_q;
    logic [N:0]   acc_ext, md_ext, sum;

    always_comb begin
        acc_ext = {sgn_q & hi_q[N-1], hi_q};
        md_ext  = {sgn_q & md_q[N-1], md_q};
    end

    shiftmul_addsub #(.N(N)) u_addsub (
        .acc_ext (acc_ext),
        .md_ext  (md_ext),
        .en_add  (lo_q[0]),
        .negate  (sgn_q & last_step),
        .sum     (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            md_q  <= '0;
            sgn_q <= 1'b0;
        end else if (load) begin
            hi_q  <= '0;
            lo_q  <= mplier;
            md_q  <= mcand;
            sgn_q <= mode_signed;
        end else if (step) begin
            hi_q <= sum[N:1];
            lo_q <= {sum[0], lo_q[N-1:1]};
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

    AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(md_q) && $stable(sgn_q))); // R7
    AST_LOAD_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hi_q == '0)); // R2
endmodule

// File: rtl/shiftmul_top.sv
module shiftmul_top #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         mode_signed,
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] prod_hi,
    output logic [N-1:0] prod_lo
);
    logic load, step, last_step;

    shiftmul_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step      (step),
        .last_step (last_step),
        .busy      (busy),
        .done      (done)
    );

    shiftmul_datapath #(.N(N)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .last_step   (last_step),
        .busy        (busy),
        .mode_signed (mode_signed),
        .mcand       (mcand),
        .mplier      (mplier),
        .hi          (prod_hi),
        .lo          (prod_lo)
    );

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo))); // R8
    AST_BUSY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done) |=> !busy); // R3
endmodule

// File: tb/tb_shiftmul_top.sv
module tb_shiftmul_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int W4 = 4;
    localparam int NVEC = 10;

    // {mode_signed, mcand, mplier}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b0, 32'h0000_0000, 32'hDEAD_BEEF},
        {1'b0, 32'h0000_0001, 32'hFFFF_FFFF},
        {1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
        {1'b0, 32'h8000_0000, 32'h0000_0002},
        {1'b0, 32'hC0FF_EE01, 32'h8000_0001},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 32'hFFFF_FFF9, 32'h0000_0005},
        {1'b1, 32'h0000_0007, 32'hFFFF_FFFB},
        {1'b1, 32'h0001_2345, 32'hFFFE_0001},
        {1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFD}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          start = 1'b0, sgn = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic          busy, done;
    logic [W-1:0]  hi, lo;

    logic          start4 = 1'b0, sgn4 = 1'b0;
    logic [W4-1:0] a4 = '0, b4 = '0;
    logic          busy4, done4;
    logic [W4-1:0] hi4, lo4;

    int n_checks = 0;
    int n_fail = 0;

    shiftmul_top #(.N(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_signed(sgn),
        .mcand(a), .mplier(b), .busy(busy), .done(done),
        .prod_hi(hi), .prod_lo(lo)
    );

    shiftmul_top #(.N(W4)) dut_w4 (
        .clk(clk), .rst_n(rst_n), .start(start4), .mode_signed(sgn4),
        .mcand(a4), .mplier(b4), .busy(busy4), .done(done4),
        .prod_hi(hi4), .prod_lo(lo4)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input bit s, input logic [31:0] x, input logic [31:0] y);
        if (s) return 64'($signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y}));
        return {32'b0, x} * {32'b0, y};
    endfunction

    task automatic run32(input bit s, input logic [31:0] x, input logic [31:0] y,
                         input string req, input bit intrude);
        logic [63:0] exp;
        logic [63:0] got;
        int cycles;
        exp = ref_prod(s, x, y);
        @(negedge clk);
        start = 1'b1; sgn = s; a = x; b = y;
        @(negedge clk);
        start = 1'b0; a = ~x; b = ~y; sgn = ~s;
        check(busy === 1'b1, "R2", {63'b0, busy}, 64'd1);
        cycles = 0;
        while (!done && cycles < 200) begin
            @(negedge clk);
            cycles++;
            start = (intrude && cycles == 5);
        end
        start = 1'b0;
        check(cycles == W, intrude ? "R7" : "R3", 64'(cycles), 64'(W));
        check({hi, lo} === exp, req, {hi, lo}, exp);
        got = {hi, lo};
        @(negedge clk);
        check({busy, done} === 2'b00, "R9", {62'b0, busy, done}, 64'd0);
        repeat (3) begin
            a = a + 32'h1357; b = b ^ 32'hFFFF; sgn = ~sgn;
            @(negedge clk);
        end
        check({hi, lo} === got, "R8", {hi, lo}, got);
    endtask

    task automatic run4(input bit s, input logic [3:0] x, input logic [3:0] y,
                        input logic [7:0] exp, input string req);
        int cycles;
        @(negedge clk);
        start4 = 1'b1; sgn4 = s; a4 = x; b4 = y;
        @(negedge clk);
        start4 = 1'b0; a4 = ~x; b4 = ~y;
        cycles = 0;
        while (!done4 && cycles < 50) begin
            @(negedge clk);
            cycles++;
        end
        check(cycles == W4, "R3", 64'(cycles), 64'(W4));
        check({hi4, lo4} === exp, req, {56'b0, hi4, lo4}, {56'b0, exp});
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, done, hi, lo} === '0, "R1", {hi, lo}, 64'd0);
        check({busy4, done4, hi4, lo4} === '0, "R1", {56'b0, hi4, lo4}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R4 unsigned, R5 signed
        for (int i = 0; i < NVEC; i++) begin
            run32(VEC[i][64], VEC[i][63:32], VEC[i][31:0], VEC[i][64] ? "R5" : "R4", 1'b0);
        end

        // R6: extreme operands
        run32(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6", 1'b0);
        run32(1'b1, 32'h8000_0000, 32'h8000_0000, "R6", 1'b0);
        run32(1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R6", 1'b0);
        run32(1'b1, 32'h7FFF_FFFF, 32'h8000_0000, "R6", 1'b0);

        // R7: start mid-run is ignored
        run32(1'b1, 32'hFFFF_FF00, 32'h0000_0123, "R7", 1'b1);
        run32(1'b0, 32'hABCD_0001, 32'hF000_000F, "R7", 1'b1);

        // 4-bit worked products
        run4(1'b0, 4'b1100, 4'b1101, 8'b1001_1100, "R4");
        run4(1'b1, 4'b1100, 4'b1101, 8'b0000_1100, "R5");
        run4(1'b1, 4'b1100, 4'b0101, 8'b1110_1100, "R5");
        run4(1'b1, 4'b1000, 4'b1000, 8'b0100_0000, "R6");
        run4(1'b0, 4'b1111, 4'b1111, 8'b1110_0001, "R6");

        summary();
        $finish;
    end
endmodule